// File: doc/BRIEF.md
# Greedy-Then-Oldest Warp Scheduler

This block picks, on every cycle, at most one warp to issue from a set of resident warp slots (64 by default). A warp slot becomes resident when a new warp is allocated to it and stops being resident when the warp is released. At allocation the slot receives an age stamp. The stamp is a sequence number that only grows, so a smaller stamp means an older warp. A resident warp may issue only when none of its three wait conditions is raised (outstanding memory access, operand dependency, barrier) and the shared execution resources report themselves free for the cycle.

The selection is greedy first. The warp that was granted most recently keeps the grant for as long as it stays eligible. When it drops out, the grant moves in the same cycle to the eligible warp with the smallest age stamp, so no idle cycle is spent on the switch. The grant is combinational from the current wait inputs and the registered slot state. It is presented both as an index and as a one-hot vector, with a valid flag.

Top module: `gto_warp_sched`

## Requirements
- R1: After a synchronous active-high reset, no slot is resident, `grant_valid` is 0 and `grant_onehot` is all zero.
- R2: A slot is granted only if it is resident, its `mem_wait`, `dep_wait` and `bar_wait` bits are all 0, and `exec_ready` is 1. With `exec_ready` at 0, nothing is granted.
- R3: Whenever at least one slot is eligible, a grant is issued in that same cycle.
- R4: If the slot granted in the previous cycle is still eligible, and was not released in that previous cycle, it is granted again, even when older eligible slots exist.
- R5: If there is no greedy slot, or the greedy slot is not eligible, the grant goes to the eligible slot with the smallest age stamp.
- R6: When no slot is eligible, `grant_valid` is 0 and `grant_onehot` is zero. The greedy slot is kept, and it is granted again once it becomes eligible.
- R7: Age stamps are handed out in allocation order, starting at 0 after reset. A slot that is allocated again after a release becomes the youngest. If allocation and release name the same slot in the same cycle, the allocation wins.
- R8: A release clears the slot's residency from the next cycle on. A released slot is never granted afterwards unless it is allocated again. Releasing the greedy slot makes the next choice oldest-first.
- R9: `grant_onehot` has exactly bit `grant_idx` set when `grant_valid` is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate a warp to `alloc_slot` at this edge |
| alloc_slot | input | SLOT_W | Slot receiving the new warp |
| release_valid | input | 1 | Release the warp in `release_slot` at this edge |
| release_slot | input | SLOT_W | Slot being released |
| mem_wait | input | NUM_SLOTS | Per slot: memory access outstanding |
| dep_wait | input | NUM_SLOTS | Per slot: operand dependency outstanding |
| bar_wait | input | NUM_SLOTS | Per slot: waiting at a barrier |
| exec_ready | input | 1 | Execution resources free this cycle |
| grant_valid | output | 1 | A warp is granted this cycle |
| grant_idx | output | SLOT_W | Index of the granted slot |
| grant_onehot | output | NUM_SLOTS | One-hot form of the granted slot |

## Verification
A short directed run allocates three warps out of index order. Because of this, picking by age and picking by lowest index give different answers. The run then raises each wait kind in turn and drops `exec_ready`, which separates "greedy warp held" from "older warp preferred" and "nothing eligible". It also re-allocates a slot so that a young warp sits at a low index, and issues an allocation and a release to the same slot together. Three random phases follow, with light, medium and heavy stall rates plus random allocation and release. The light phase mostly exercises greedy retention, the heavy phase mostly exercises the oldest-first fallback and idle cycles, and each cycle is compared with a behavioural model kept in the bench.

// File: rtl/gto_pkg.sv
package gto_pkg;

    // Upper bound on slots and width of the age stamp
    localparam int unsigned MAX_SLOTS = 64;
    localparam int unsigned IDX_W     = $clog2(MAX_SLOTS);
    localparam int unsigned SEQ_W     = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [IDX_W-1:0] pidx_t;

    // One candidate travelling up the age-comparison tree
    typedef struct packed {
        logic  vld;
        seq_t  seq;
        pidx_t idx;
    } cand_t;

    // Keep the older of two candidates; an invalid side always loses
    function automatic cand_t older_of(input cand_t a, input cand_t b);
        if (a.vld && (!b.vld || (a.seq < b.seq))) begin
            return a;
        end
        return b;
    endfunction

endpackage

// File: rtl/gto_age_table.sv
module gto_age_table
    import gto_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 64,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [SLOT_W-1:0]    alloc_slot,
    input  logic                 release_valid,
    input  logic [SLOT_W-1:0]    release_slot,
    output logic [NUM_SLOTS-1:0] resident_o,
    output seq_t                 seq_o [NUM_SLOTS]
);

    logic [NUM_SLOTS-1:0] resident_q;
    seq_t                 seq_q [NUM_SLOTS];
    seq_t                 next_seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resident_q <= '0;
            next_seq_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                seq_q[i] <= '0;
            end
        end else begin
            if (release_valid) begin
                resident_q[release_slot] <= 1'b0;
            end
            // later assignment: allocation overrides a same-slot release
            if (alloc_valid) begin
                resident_q[alloc_slot] <= 1'b1;
                seq_q[alloc_slot]      <= next_seq_q;
                next_seq_q             <= next_seq_q + 1'b1;
            end
        end
    end

    assign resident_o = resident_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_seq_out
        assign seq_o[s] = seq_q[s];
    end

    // R7: an allocated slot is resident at the next edge
    p_alloc_resident_r7: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> resident_q[$past(alloc_slot)]);

    // R8: a release without a same-slot allocation clears residency
    p_release_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (release_valid && !(alloc_valid && (alloc_slot == release_slot)))
        |=> !resident_q[$past(release_slot)]);

endmodule

// File: rtl/gto_oldest_pick.sv
module gto_oldest_pick
    import gto_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 64,
    localparam int unsigned LVLS      = $clog2(NUM_SLOTS),
    localparam int unsigned PAD       = 1 << LVLS
) (
    input  logic [NUM_SLOTS-1:0] elig_i,
    input  seq_t                 seq_i [NUM_SLOTS],
    output cand_t                oldest_o
);

    // Balanced tree: level 0 holds the leaves, level LVLS the root
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int unsigned W = PAD >> l;
        cand_t nd [W];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_i
                if (i < NUM_SLOTS) begin : g_real
                    assign nd[i] = '{vld: elig_i[i], seq: seq_i[i], idx: IDX_W'(i)};
                end else begin : g_pad
                    assign nd[i] = '{vld: 1'b0, seq: '0, idx: '0};
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_i
                assign nd[i] = older_of(g_lvl[l-1].nd[2*i], g_lvl[l-1].nd[2*i+1]);
            end
        end
    end

    assign oldest_o = g_lvl[LVLS].nd[0];

    // R5: the root only ever names an eligible slot
    always_comb begin
        if (oldest_o.vld) begin
            p_pick_eligible_r5: assert (elig_i[oldest_o.idx]);
        end
    end

endmodule

// File: rtl/gto_warp_sched.sv
module gto_warp_sched
    import gto_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 64,   // 2 .. MAX_SLOTS
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [SLOT_W-1:0]    alloc_slot,
    input  logic                 release_valid,
    input  logic [SLOT_W-1:0]    release_slot,
    input  logic [NUM_SLOTS-1:0] mem_wait,
    input  logic [NUM_SLOTS-1:0] dep_wait,
    input  logic [NUM_SLOTS-1:0] bar_wait,
    input  logic                 exec_ready,
    output logic                 grant_valid,
    output logic [SLOT_W-1:0]    grant_idx,
    output logic [NUM_SLOTS-1:0] grant_onehot
);

    logic [NUM_SLOTS-1:0] resident;
    seq_t                 seq_arr [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] eligible;
    cand_t                oldest;

    logic                 greedy_vld_q;
    logic [SLOT_W-1:0]    greedy_idx_q;
    logic                 greedy_hit;

    gto_age_table #(.NUM_SLOTS(NUM_SLOTS)) u_age (
        .clk          (clk),
        .rst          (rst),
        .alloc_valid  (alloc_valid),
        .alloc_slot   (alloc_slot),
        .release_valid(release_valid),
        .release_slot (release_slot),
        .resident_o   (resident),
        .seq_o        (seq_arr)
    );

    assign eligible = resident & ~mem_wait & ~dep_wait & ~bar_wait
                    & {NUM_SLOTS{exec_ready}};

    gto_oldest_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .elig_i  (eligible),
        .seq_i   (seq_arr),
        .oldest_o(oldest)
    );

    // Greedy warp first, otherwise the oldest eligible one
    assign greedy_hit  = greedy_vld_q && eligible[greedy_idx_q];
    assign grant_valid = greedy_hit || oldest.vld;
    assign grant_idx   = greedy_hit ? greedy_idx_q : oldest.idx[SLOT_W-1:0];

    always_comb begin
        grant_onehot = '0;
        if (grant_valid) begin
            grant_onehot[grant_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            greedy_vld_q <= 1'b0;
            greedy_idx_q <= '0;
        end else if (grant_valid) begin
            greedy_idx_q <= grant_idx;
            greedy_vld_q <= !(release_valid && (release_slot == grant_idx));
        end else if (release_valid && (release_slot == greedy_idx_q)) begin
            greedy_vld_q <= 1'b0;
        end
    end

    // R2: every grant names a resident, unstalled slot with resources free
    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (exec_ready && resident[grant_idx] && !mem_wait[grant_idx]
                         && !dep_wait[grant_idx] && !bar_wait[grant_idx]));

    // R3: no idle cycle while something could issue
    p_no_bubble_r3: assert property (@(posedge clk) disable iff (rst)
        (|eligible) |-> grant_valid);

    // R4: the last granted warp keeps the grant while eligible
    p_greedy_keep_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(grant_valid)
         && !($past(release_valid) && ($past(release_slot) == $past(grant_idx)))
         && eligible[$past(grant_idx)])
        |-> (grant_valid && (grant_idx == $past(grant_idx))));

    // R6: idle cycle leaves the greedy pointer untouched
    p_idle_keeps_greedy_r6: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && !release_valid) |=> (greedy_idx_q == $past(greedy_idx_q)
                                              && greedy_vld_q == $past(greedy_vld_q)));

    // R9: one-hot form agrees with the valid flag
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_onehot) && (grant_valid == (|grant_onehot)));

endmodule

// File: tb/sim_gto_warp_sched.sv
module sim_gto_warp_sched;

    localparam int N  = 64;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [SW-1:0] alloc_slot = '0;
    logic          release_valid = 1'b0;
    logic [SW-1:0] release_slot = '0;
    logic [N-1:0]  mem_wait = '0;
    logic [N-1:0]  dep_wait = '0;
    logic [N-1:0]  bar_wait = '0;
    logic          exec_ready = 1'b1;
    logic          grant_valid;
    logic [SW-1:0] grant_idx;
    logic [N-1:0]  grant_onehot;

    always #10 clk = ~clk;   // 50 MHz

    gto_warp_sched #(.NUM_SLOTS(N)) u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
        .release_valid(release_valid), .release_slot(release_slot),
        .mem_wait(mem_wait), .dep_wait(dep_wait), .bar_wait(bar_wait),
        .exec_ready(exec_ready),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_onehot(grant_onehot)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit     m_res [N];
    longint m_seq [N];
    longint m_next = 0;
    bit     m_gv = 0;
    int     m_gi = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_elig(input int i);
        return m_res[i] && !mem_wait[i] && !dep_wait[i] && !bar_wait[i] && exec_ready;
    endfunction

    task automatic clr();
        alloc_valid = 0; release_valid = 0;
        mem_wait = '0; dep_wait = '0; bar_wait = '0; exec_ready = 1;
    endtask

    // Called at a falling edge with inputs set; want: -2 none given, -1 idle, else slot
    task automatic step(input string tag, input int want);
        int  ei;
        bit  ev;
        bit  fg;
        string t;
        logic [N-1:0] oh;
        #2;
        ei = -1; fg = 0;
        if (m_gv && m_elig(m_gi)) begin
            ei = m_gi; fg = 1;
        end else begin
            for (int i = 0; i < N; i++)
                if (m_elig(i) && (ei < 0 || m_seq[i] < m_seq[ei])) ei = i;
        end
        ev = (ei >= 0);
        t = !ev ? (exec_ready ? "R6" : "R2") : (fg ? "R4" : "R5 R3");
        chk(grant_valid == ev, t, grant_valid, ev);
        if (ev) chk(grant_idx == ei, t, grant_idx, ei);
        oh = '0;
        if (ev) oh[ei] = 1'b1;
        chk(grant_onehot == oh, "R9", grant_onehot, oh);
        if (want != -2) begin
            if (want == -1) chk(!grant_valid, tag, grant_valid, 0);
            else chk(grant_valid && grant_idx == want, tag,
                     grant_valid ? grant_idx : -1, want);
        end
        @(posedge clk);
        if (ev) begin
            m_gi = ei;
            m_gv = !(release_valid && release_slot == ei);
        end else if (release_valid && release_slot == m_gi) begin
            m_gv = 0;
        end
        if (release_valid) m_res[release_slot] = 0;
        if (alloc_valid) begin
            m_res[alloc_slot] = 1; m_seq[alloc_slot] = m_next; m_next++;
        end
        @(negedge clk);
    endtask

    task automatic rand_phase(input int cycles, input int stall_pct);
        for (int c = 0; c < cycles; c++) begin
            int s;
            clr();
            s = $urandom_range(0, N-1);
            if ($urandom_range(0, 99) < 20 && !m_res[s]) begin
                alloc_valid = 1; alloc_slot = SW'(s);
            end
            s = $urandom_range(0, N-1);
            if ($urandom_range(0, 99) < 8 && m_res[s]) begin
                release_valid = 1; release_slot = SW'(s);
            end
            for (int i = 0; i < N; i++) begin
                mem_wait[i] = ($urandom_range(0, 99) < stall_pct);
                dep_wait[i] = ($urandom_range(0, 99) < stall_pct / 2);
                bar_wait[i] = ($urandom_range(0, 99) < stall_pct / 4);
            end
            exec_ready = ($urandom_range(0, 99) >= 10);
            step("random", -2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_res[i] = 0; m_seq[i] = 0; end
        repeat (3) @(negedge clk);
        #2;
        chk(!grant_valid, "R1 valid in reset", grant_valid, 0);
        chk(grant_onehot == '0, "R1 onehot in reset", grant_onehot, 0);
        rst = 0;
        @(negedge clk);
        clr();
        step("R1 nothing resident", -1);

        // allocate out of index order: 5 (age 0), 2 (age 1), 9 (age 2)
        alloc_valid = 1; alloc_slot = 5; step("R7 alloc", -1);
        alloc_slot = 2; step("R5 only one resident", 5);
        alloc_slot = 9; step("R4 keep", 5);
        clr();
        step("R4 keep greedy", 5);
        mem_wait[5] = 1; step("R5 switch to oldest same cycle", 2);
        mem_wait[5] = 0; step("R4 greedy beats older", 2);
        exec_ready = 0;  step("R2 resources busy", -1);
        exec_ready = 1; dep_wait[5] = 1; dep_wait[2] = 1; dep_wait[9] = 1;
        step("R6 all stalled", -1);
        dep_wait = '0;   step("R6 greedy kept after idle", 2);
        bar_wait[2] = 1; step("R2 barrier wait", 5);
        bar_wait[2] = 0; release_valid = 1; release_slot = 5;
        step("R8 release takes effect next cycle", 5);
        clr();           step("R8 fallback to oldest", 2);
        alloc_valid = 1; alloc_slot = 5; step("R7 realloc", 2);
        clr(); dep_wait[2] = 1;
        step("R7 reallocated slot is youngest", 9);
        alloc_valid = 1; alloc_slot = 9; release_valid = 1; release_slot = 9;
        step("R7 alloc and release same slot", 9);
        clr(); dep_wait[2] = 1;
        step("R8 R7 greedy dropped, slot 9 now youngest", 5);
        clr();

        rand_phase(600, 10);
        rand_phase(600, 45);
        rand_phase(600, 85);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule